// File: doc/BRIEF.md
# Fault Address Store with Redundant Word Remap

This block sits beside an embedded SRAM that gives up its top few words as spares. While a self-test engine runs, each time a compared read fails the engine raises a strobe together with the address of the failing word. The block keeps each distinct failing address once, in a small table with one entry per spare word. Entry `i` always belongs to spare word `i`. Every entry is compared against the incoming address in parallel, so an address that fails again in a later read pass is recognised and dropped. The block also keeps a count of stored addresses and a sticky overflow flag for the case where there are more distinct faults than spares.

In normal operation the system access address goes through the block on its way to the array. When repair is enabled and the address matches a stored entry, the block sends out the address of the paired spare word instead. The remap is combinational and adds no latency. When repair is disabled, addresses pass through untouched, so the spare words can be used as ordinary storage.

Empty entries hold the address of their own spare word after reset. A normal address therefore never matches an entry that has not been filled, and the compare logic needs no valid bits.

Top module: `fault_addr_store`

## Requirements
- R1: After reset, `fault_cnt_o` is 0, `overflow_o` is 0, and no normal address (below `2**ADDR_W - N_SPARE`) is remapped, even with repair enabled.
- R2: A strobe on `fault_vld_i` carrying a normal address that is not yet stored, while fewer than `N_SPARE` entries are used, stores the address in entry `fault_cnt_o`. `fault_cnt_o` goes up by one on the next clock edge.
- R3: A strobe carrying an address that is already stored leaves the count, the table and `overflow_o` unchanged.
- R4: A strobe carrying a new normal address while all `N_SPARE` entries are used sets `overflow_o` on the next edge and leaves the table and the count unchanged.
- R5: With `repair_en_i` = 0, `mem_addr_o` equals `acc_addr_i` and `remap_hit_o` is 0 for every address, spare addresses included.
- R6: With `repair_en_i` = 1, an access to the address stored in entry `i` drives `mem_addr_o` = `2**ADDR_W - N_SPARE + i` and sets `remap_hit_o` to 1. Entry `i` is the `i`-th distinct fault stored, counting from 0.
- R7: With `repair_en_i` = 1, an access to an address that is not stored passes through unchanged with `remap_hit_o` = 0.
- R8: A strobe whose address lies in the spare region (at or above `2**ADDR_W - N_SPARE`) is ignored: neither the count nor the overflow flag changes.
- R9: `overflow_o` stays set until reset, and `fault_cnt_o` never exceeds `N_SPARE`.
- R10: The remap is combinational: `mem_addr_o` and `remap_hit_o` follow `acc_addr_i` and `repair_en_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; loads the background addresses |
| fault_vld_i | input | 1 | One-cycle strobe: a compared read failed |
| fault_addr_i | input | ADDR_W | Address of the failing word |
| repair_en_i | input | 1 | 1: redirect stored faulty addresses to spares |
| acc_addr_i | input | ADDR_W | System access address |
| mem_addr_o | output | ADDR_W | Address presented to the array |
| remap_hit_o | output | 1 | Access was redirected to a spare word |
| fault_cnt_o | output | $clog2(N_SPARE+1) | Number of distinct faulty addresses stored |
| overflow_o | output | 1 | Sticky: a new fault arrived while the table was full |

## Verification
The bench sends repeated faults at the same address from a small address pool. A design that did not deduplicate would use up spares, and the counts would drift away from the model. It sends repeated faults once the table is full. Here a design that counted duplicates as new faults would raise overflow by mistake, and one that wrote while full would corrupt existing mappings, which the remap checks after each step would catch. Strobes in the spare region and accesses to spare addresses under both repair settings expose a design that mistakes a background entry for a stored fault. Every access is checked in its own cycle, so a registered remap path would fail.

// File: rtl/fas_pkg.sv
package fas_pkg;
  // index width that stays at least one bit for a single-entry table
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fas_cam.sv
module fas_cam #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned N_SPARE = 4,
  localparam int unsigned IDX_W  = fas_pkg::idx_w(N_SPARE),
  localparam int unsigned NORMAL = (1 << ADDR_W) - N_SPARE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [ADDR_W-1:0]  look_a_i,
  input  logic [ADDR_W-1:0]  look_b_i,
  output logic [N_SPARE-1:0] match_a_o,
  output logic [N_SPARE-1:0] match_b_o
);
  logic [ADDR_W-1:0] ent_q [N_SPARE];

  for (genvar i = 0; i < N_SPARE; i++) begin : g_ent
    // background value: own spare address, so empty entries never match normal words
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ent_q[i] <= ADDR_W'(NORMAL + i);
      else if (wr_en_i && (wr_idx_i == IDX_W'(i)))
        ent_q[i] <= wr_addr_i;
    end
    assign match_a_o[i] = (ent_q[i] == look_a_i);
    assign match_b_o[i] = (ent_q[i] == look_b_i);
  end

  // R2: a write only ever replaces a background entry
  a_r2_write_free_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_addr_i < ADDR_W'(NORMAL)) && !(|match_a_o));
endmodule

// File: rtl/fas_remap.sv
module fas_remap #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned N_SPARE = 4,
  localparam int unsigned IDX_W  = fas_pkg::idx_w(N_SPARE),
  localparam int unsigned NORMAL = (1 << ADDR_W) - N_SPARE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SPARE-1:0] match_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic               repair_en_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               hit_o
);
  logic [IDX_W-1:0] idx;
  logic             normal_acc;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_SPARE; i++)
      if (match_i[i]) idx = idx | IDX_W'(i);
  end

  assign normal_acc = (acc_addr_i < ADDR_W'(NORMAL));
  assign hit_o      = repair_en_i && normal_acc && (|match_i);
  assign mem_addr_o = hit_o ? (ADDR_W'(NORMAL) + ADDR_W'(idx)) : acc_addr_i;

  // R6: stored addresses are distinct, so at most one entry matches
  a_r6_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_i));
  // R6: a redirected access always lands in the spare region
  a_r6_hit_to_spare: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> mem_addr_o >= ADDR_W'(NORMAL));
endmodule

// File: rtl/fault_addr_store.sv
module fault_addr_store #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned N_SPARE = 4,
  localparam int unsigned IDX_W  = fas_pkg::idx_w(N_SPARE),
  localparam int unsigned CNT_W  = $clog2(N_SPARE + 1),
  localparam int unsigned NORMAL = (1 << ADDR_W) - N_SPARE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_vld_i,
  input  logic [ADDR_W-1:0] fault_addr_i,
  input  logic              repair_en_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              remap_hit_o,
  output logic [CNT_W-1:0]  fault_cnt_o,
  output logic              overflow_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic               ovf_q;
  logic [N_SPARE-1:0] fmatch, amatch;
  logic               in_spare, dup, full, is_new, store, ovf_set;

  assign in_spare = (fault_addr_i >= ADDR_W'(NORMAL));
  assign dup      = |fmatch;
  assign full     = (cnt_q == CNT_W'(N_SPARE));
  assign is_new   = fault_vld_i && !in_spare && !dup;
  assign store    = is_new && !full;
  assign ovf_set  = is_new && full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (store)   cnt_q <= cnt_q + CNT_W'(1);
      if (ovf_set) ovf_q <= 1'b1;
    end
  end

  fas_cam #(.ADDR_W(ADDR_W), .N_SPARE(N_SPARE)) u_cam (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (store),
    .wr_idx_i  (IDX_W'(cnt_q)),
    .wr_addr_i (fault_addr_i),
    .look_a_i  (fault_addr_i),
    .look_b_i  (acc_addr_i),
    .match_a_o (fmatch),
    .match_b_o (amatch)
  );

  fas_remap #(.ADDR_W(ADDR_W), .N_SPARE(N_SPARE)) u_remap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .match_i     (amatch),
    .acc_addr_i  (acc_addr_i),
    .repair_en_i (repair_en_i),
    .mem_addr_o  (mem_addr_o),
    .hit_o       (remap_hit_o)
  );

  assign fault_cnt_o = cnt_q;
  assign overflow_o  = ovf_q;

  a_r3_dup_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_vld_i && dup) |=> $stable(cnt_q) && $stable(ovf_q));
  a_r8_spare_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_vld_i && in_spare) |=> $stable(cnt_q) && $stable(ovf_q));
  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N_SPARE));
  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r4_ovf_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(cnt_q) == CNT_W'(N_SPARE) && $stable(cnt_q));
  a_r5_no_repair_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !repair_en_i |-> !remap_hit_o && (mem_addr_o == acc_addr_i));
endmodule

// File: tb/sim_fault_addr_store.sv
module sim_fault_addr_store;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned N_SPARE = 4;
  localparam int unsigned CNT_W   = $clog2(N_SPARE + 1);
  localparam int unsigned NORMAL  = (1 << ADDR_W) - N_SPARE;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              fault_vld = 1'b0;
  logic [ADDR_W-1:0] fault_addr = '0;
  logic              repair_en = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic              hit;
  logic [CNT_W-1:0]  cnt;
  logic              ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int exp_tab [N_SPARE];
  int exp_cnt = 0;
  bit exp_ovf = 0;

  always #2.5 clk = ~clk;

  fault_addr_store #(.ADDR_W(ADDR_W), .N_SPARE(N_SPARE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fault_vld_i(fault_vld), .fault_addr_i(fault_addr),
    .repair_en_i(repair_en), .acc_addr_i(acc_addr), .mem_addr_o(mem_addr),
    .remap_hit_o(hit), .fault_cnt_o(cnt), .overflow_o(ovf)
  );

  function automatic int exp_map(input int a, input bit en);
    if (!en || a >= int'(NORMAL)) return a;
    for (int k = 0; k < exp_cnt; k++)
      if (exp_tab[k] == a) return int'(NORMAL) + k;
    return a;
  endfunction

  function automatic bit is_stored(input int a);
    for (int k = 0; k < exp_cnt; k++)
      if (exp_tab[k] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    fault_vld = 1'b0;
    exp_cnt = 0;
    exp_ovf = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic fault(input int a, input string req);
    @(negedge clk);
    fault_vld  = 1'b1;
    fault_addr = ADDR_W'(a);
    @(negedge clk);
    fault_vld = 1'b0;
    if (a < int'(NORMAL) && !is_stored(a)) begin
      if (exp_cnt < int'(N_SPARE)) begin
        exp_tab[exp_cnt] = a;
        exp_cnt++;
      end else exp_ovf = 1'b1;
    end
    check(req, "fault_cnt", int'(cnt), exp_cnt);
    check(req, "overflow", int'(ovf), int'(exp_ovf));
  endtask

  // R10: inputs change and outputs are checked inside the same cycle
  task automatic access(input int a, input bit en, input string req);
    @(negedge clk);
    acc_addr  = ADDR_W'(a);
    repair_en = en;
    #1;
    check(req, "mem_addr", int'(mem_addr), exp_map(a, en));
    check(req, "hit", int'(hit), int'(exp_map(a, en) != a));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    check("R1", "reset count", int'(cnt), 0);
    check("R1", "reset overflow", int'(ovf), 0);
    for (int a = 0; a < int'(NORMAL); a++) access(a, 1'b1, "R1");

    // directed
    fault(10, "R2");
    access(10, 1'b1, "R6 R10");
    fault(10, "R3");
    fault(62, "R8");
    access(62, 1'b1, "R7");
    access(10, 1'b0, "R5");
    access(61, 1'b0, "R5");
    access(61, 1'b1, "R7");
    access(11, 1'b1, "R7");
    fault(0, "R2");
    fault(59, "R2");
    fault(33, "R2");
    access(0, 1'b1, "R6");
    access(59, 1'b1, "R6");
    access(33, 1'b1, "R6");
    fault(33, "R3");
    check("R4", "no overflow on duplicate when full", int'(ovf), 0);
    fault(5, "R4");
    access(5, 1'b1, "R4");
    access(10, 1'b1, "R4");
    fault(6, "R9");
    fault(63, "R9");
    check("R9", "count bound", int'(cnt), int'(N_SPARE));
    do_reset();
    check("R1", "overflow cleared", int'(ovf), 0);
    access(10, 1'b1, "R1");

    // random rounds with a small address pool to force duplicates
    for (int r = 0; r < 6; r++) begin
      do_reset();
      for (int n = 0; n < 30; n++) begin
        int unsigned pick;
        pick = $urandom % 10;
        if (pick < 9) fault(int'(pick * 7), "R2 R3 R4");
        else fault(int'(NORMAL) + int'($urandom % N_SPARE), "R8");
        access(int'(($urandom % 10) * 7), 1'($urandom % 2), "R5 R6 R7");
        access(int'($urandom % (1 << ADDR_W)), 1'($urandom % 2), "R5 R6 R7");
      end
      check("R9", "random count bound", int'(cnt <= CNT_W'(N_SPARE)), 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule